// File: doc/BRIEF.md
# Configurable Synchronous Burst Read Controller

This block is the read-side sequencer of a burst-capable memory. A 16-bit configuration word, loaded through a simple write strobe, chooses between a plain asynchronous read and a synchronous burst. In asynchronous mode the requested address goes straight through to the array and the block stays idle.

In synchronous mode the controller runs on the burst clock input. Each burst clock event on the selected edge is one "tick", detected with the system clock. While chip enable is high, an address-latch strobe seen on a tick captures the start address. After a programmable number of ticks the controller begins to issue word addresses and a data-valid strobe. The address order is sequential, interleaved, wrapped or linear. Each word is held for one or two ticks. A WAIT output tells the host when data is not yet valid. Its polarity and its early-or-aligned timing can both be set. Dropping chip enable ends the burst.

Configuration writes are accepted at any time. While a burst is running, a write is parked and takes effect once chip enable falls. Writes that carry an illegal latency code are discarded whole.

Top module: `burst_rd_ctrl`

## Requirements
- R1: After reset the configuration is 0x95CF. In that state reads are asynchronous: word_addr equals start_addr, data_valid stays 0 on every tick, and wait_out sits at its inactive level 0.
- R2: A configuration write whose latency field, bits 13:11, is 000 or 001 is discarded entirely. The previous configuration stays in force.
- R3: Take the tick that latches the address, with chip enable and the latch strobe both high and bit 15 at 0. After it, data_valid stays 0 for the following L-1 ticks, where L is the latency field. It rises after the L-th tick.
- R4: bit 10 selects the WAIT polarity: 1 means active high, 0 means active low. Bit 8 selects the timing. With 0, WAIT is active on every latency tick. With 1, it goes inactive one tick early, on the last latency tick. Whenever data_valid is 1, WAIT is at its inactive level.
- R5: bit 7 selects the order: 1 means sequential, 0 means interleaved. Bits 2:0 set the burst length: 001 gives 4 words, 010 gives 8 words, and any other code is continuous. With sequential order, bit 3 at 0 (wrap) and a 4- or 8-word length, word i is formed as follows. The upper address bits come from the start address. The low bits are (start + i) modulo the length.
- R6: With interleaved order and a 4- or 8-word length, word i keeps the upper bits of the start address. Its low bits are the start's low bits XOR i.
- R7: A continuous length, or sequential order with bit 3 at 1, gives word i = start + i, modulo 2^AW.
- R8: With bit 9 at 0, each word lasts one tick. With bit 9 at 1, each word lasts two ticks.
- R9: With bit 6 at 1, only rising edges of k_clk advance the burst. With bit 6 at 0, only falling edges do. An edge of the other direction leaves word_addr and data_valid unchanged.
- R10: A legal configuration write made during a burst does not change the running burst. It takes effect for the next burst, after chip enable has been low.
- R11: Chip enable low ends the burst. data_valid is 0 one system clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples k_clk and all controls |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word to write |
| ce | input | 1 | Chip enable, active high |
| adv | input | 1 | Address-latch strobe, active high, sampled on a tick |
| k_clk | input | 1 | Burst clock; the selected edge forms a tick |
| start_addr | input | AW | Requested word address |
| word_addr | output | AW | Word address presented to the array |
| data_valid | output | 1 | Array data is valid for word_addr |
| wait_out | output | 1 | WAIT indication, configurable polarity and timing |

## Verification
The assertions assume three things about the inputs. k_clk is slow relative to clk, so each level lasts at least two system clocks. The configuration never carries a latency below two, which the write filter guarantees. A burst always begins with the latch strobe on a tick while chip enable is high. The stimulus changes every input on the falling system clock edge, holds each k_clk level for two system clocks, and writes configurations only while chip enable is low. The one exception is the deliberate mid-burst write. Chip enable is lowered between bursts, so each new burst starts from the idle state.

// File: rtl/brc_pkg.sv
package brc_pkg;

  localparam logic [15:0] CFG_RESET = 16'h95CF;

  typedef struct packed {
    logic       async_rd;
    logic [2:0] lat;
    logic       wait_hi;
    logic       hold2;
    logic       wait_early;
    logic       seq;
    logic       rise;
    logic       no_wrap;
    logic [2:0] blen;
  } cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_LAT, ST_DATA} st_t;

  function automatic cfg_t cfg_decode(input logic [15:0] w);
    cfg_t c;
    c.async_rd   = w[15];
    c.lat        = w[13:11];
    c.wait_hi    = w[10];
    c.hold2      = w[9];
    c.wait_early = w[8];
    c.seq        = w[7];
    c.rise       = w[6];
    c.no_wrap    = w[3];
    c.blen       = w[2:0];
    return c;
  endfunction

  function automatic logic lat_legal(input logic [15:0] w);
    return w[13:12] != 2'b00;
  endfunction

  // number of low address bits that the burst length confines (0 = linear)
  function automatic int unsigned wrap_bits(input logic [2:0] blen);
    case (blen)
      3'b001:  return 2;
      3'b010:  return 3;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/brc_cfg_reg.sv
module brc_cfg_reg
  import brc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [15:0] wdata,
  input  logic        busy,
  input  logic        ce,
  output logic [15:0] cfg_q
);

  logic [15:0] pend_q;
  logic        pend_v;
  logic        wr_ok;
  logic        wr_now;

  assign wr_ok  = we && lat_legal(wdata);
  assign wr_now = wr_ok && (!busy || !ce);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RESET;
      pend_q <= '0;
      pend_v <= 1'b0;
    end else if (wr_now) begin
      cfg_q  <= wdata;
      pend_v <= 1'b0;
    end else if (wr_ok) begin
      pend_q <= wdata;
      pend_v <= 1'b1;
    end else if (pend_v && !ce) begin
      cfg_q  <= pend_q;
      pend_v <= 1'b0;
    end
  end

  p_lat_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[13:12] != 2'b00);

  p_defer_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ce) |=> $stable(cfg_q));

endmodule

// File: rtl/brc_edge.sv
module brc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic k_clk,
  input  logic rise,
  output logic tick
);

  logic k_q;

  always_ff @(posedge clk) begin
    if (!rst_n) k_q <= 1'b0;
    else        k_q <= k_clk;
  end

  assign tick = rise ? (k_clk & ~k_q) : (~k_clk & k_q);

  p_tick_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (!tick || !$stable(rise)));

endmodule

// File: rtl/brc_seq.sv
module brc_seq
  import brc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          ce,
  input  logic          adv,
  input  logic          sync_en,
  input  logic [2:0]    lat,
  input  logic          hold2,
  input  logic          wait_early,
  input  logic [AW-1:0] start_addr,
  output logic          busy,
  output logic          in_data,
  output logic          wait_act,
  output logic [AW-1:0] base,
  output logic [AW-1:0] idx
);

  st_t        st_q;
  logic [2:0] cnt_q;
  logic       ph_q;
  logic       latch_ev;
  logic       last_lat;

  assign latch_ev = tick && adv && sync_en;
  assign last_lat = (cnt_q == 3'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      ph_q  <= 1'b0;
      idx   <= '0;
      base  <= '0;
    end else if (!ce) begin
      st_q  <= ST_IDLE;
      ph_q  <= 1'b0;
      idx   <= '0;
    end else if (latch_ev) begin
      st_q  <= ST_LAT;
      cnt_q <= lat;
      ph_q  <= 1'b0;
      idx   <= '0;
      base  <= start_addr;
    end else if (tick) begin
      case (st_q)
        ST_LAT: begin
          if (last_lat) st_q  <= ST_DATA;
          else          cnt_q <= cnt_q - 3'd1;
        end
        ST_DATA: begin
          if (hold2 && !ph_q) begin
            ph_q <= 1'b1;
          end else begin
            ph_q <= 1'b0;
            idx  <= idx + AW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign in_data  = (st_q == ST_DATA);
  assign wait_act = (st_q == ST_LAT) && !(wait_early && last_lat);

  p_data_after_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_data) |-> $past(st_q == ST_LAT));

  p_idx_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && $past(in_data) && !$past(tick)) |-> $stable(idx));

  p_ce_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> !busy);

endmodule

// File: rtl/brc_addr.sv
module brc_addr
  import brc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          in_data,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] idx,
  input  logic          seq,
  input  logic          no_wrap,
  input  logic [2:0]    blen,
  output logic [AW-1:0] word_addr
);

  function automatic logic [AW-1:0] burst_addr(
    input logic [AW-1:0] b, input logic [AW-1:0] i,
    input logic s, input logic nw, input logic [2:0] bl);
    logic [AW-1:0] m;
    m = (AW'(1) << wrap_bits(bl)) - AW'(1);
    if (m == '0)     return b + i;
    if (!s)          return (b & ~m) | ((b ^ i) & m);
    if (nw)          return b + i;
    return (b & ~m) | ((b + i) & m);
  endfunction

  assign word_addr = in_data ? burst_addr(base, idx, seq, no_wrap, blen)
                             : start_addr;

endmodule

// File: rtl/burst_rd_ctrl.sv
module burst_rd_ctrl
  import brc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [15:0]   cfg_wdata,
  input  logic          ce,
  input  logic          adv,
  input  logic          k_clk,
  input  logic [AW-1:0] start_addr,
  output logic [AW-1:0] word_addr,
  output logic          data_valid,
  output logic          wait_out
);

  logic [15:0]   cfg_q;
  cfg_t          cf;
  logic          tick;
  logic          busy;
  logic          in_data;
  logic          wait_act;
  logic [AW-1:0] base;
  logic [AW-1:0] idx;

  assign cf = cfg_decode(cfg_q);

  brc_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .busy(busy), .ce(ce), .cfg_q(cfg_q)
  );

  brc_edge u_edge (
    .clk(clk), .rst_n(rst_n), .k_clk(k_clk), .rise(cf.rise), .tick(tick)
  );

  brc_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ce(ce), .adv(adv),
    .sync_en(!cf.async_rd), .lat(cf.lat), .hold2(cf.hold2),
    .wait_early(cf.wait_early), .start_addr(start_addr),
    .busy(busy), .in_data(in_data), .wait_act(wait_act),
    .base(base), .idx(idx)
  );

  brc_addr #(.AW(AW)) u_addr (
    .in_data(in_data), .start_addr(start_addr), .base(base), .idx(idx),
    .seq(cf.seq), .no_wrap(cf.no_wrap), .blen(cf.blen),
    .word_addr(word_addr)
  );

  assign data_valid = in_data;
  assign wait_out   = wait_act ? cf.wait_hi : ~cf.wait_hi;

  p_async_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cf.async_rd |-> (word_addr == start_addr && !data_valid));

  p_valid_no_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> (wait_out == ~cf.wait_hi));

  p_wrap4_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && cf.seq && !cf.no_wrap && cf.blen == 3'b001)
      |-> (word_addr[AW-1:2] == base[AW-1:2]));

endmodule

// File: tb/test_burst_rd_ctrl.sv
module test_burst_rd_ctrl;

  localparam int AW = 8;
  localparam int NV = 6;

  localparam logic [15:0] V_CFG [NV] = '{16'h15C1, 16'h1A02, 16'h25C9,
                                         16'h3C47, 16'h1141, 16'h14C3};
  localparam logic [7:0]  V_ST  [NV] = '{8'h06, 8'h2B, 8'h3E,
                                         8'hFE, 8'h11, 8'h07};
  localparam logic [63:0] V_EXP [NV] = '{64'h06_07_04_05_06_07_04_05,
                                         64'h2B_2A_29_28_2F_2E_2D_2C,
                                         64'h3E_3F_40_41_42_43_44_45,
                                         64'hFE_FF_00_01_02_03_04_05,
                                         64'h11_10_13_12_11_10_13_12,
                                         64'h07_08_09_0A_0B_0C_0D_0E};
  localparam string V_TAG [NV] = '{"R5 seq-wrap4", "R6 R8 intl8-hold2",
                                   "R7 seq-nowrap", "R7 continuous",
                                   "R6 intl4", "R7 len-other"};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [15:0]   cfg_wdata = '0;
  logic          ce = 1'b0;
  logic          adv = 1'b0;
  logic          k_clk = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [AW-1:0] word_addr;
  logic          data_valid;
  logic          wait_out;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  logic act_lvl = 1'b1;

  always #4 clk = ~clk;

  burst_rd_ctrl #(.AW(AW)) i_burst_rd_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ce(ce), .adv(adv), .k_clk(k_clk), .start_addr(start_addr),
    .word_addr(word_addr), .data_valid(data_valid), .wait_out(wait_out)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [15:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic tick_k();
    @(negedge clk); k_clk = ~act_lvl;
    @(negedge clk);
    @(negedge clk); k_clk = act_lvl;
    @(negedge clk);
  endtask

  task automatic run_burst(input bit wr, input logic [15:0] c, input logic [7:0] st,
                           input logic [63:0] exp, input string tag);
    int unsigned lat;
    logic pol;
    if (wr) wr_cfg(c);
    lat = c[13:11];
    pol = c[10];
    act_lvl = c[6];
    @(negedge clk); ce = 1'b1; adv = 1'b1; start_addr = st;
    tick_k();
    adv = 1'b0;
    for (int t = 0; t < int'(lat); t++) begin
      if (t > 0) tick_k();
      chk("R3 no data during latency", {31'd0, data_valid}, 32'd0);
      chk("R4 wait in latency", {31'd0, wait_out},
          {31'd0, (c[8] && t == int'(lat) - 1) ? ~pol : pol});
    end
    for (int w = 0; w < 8; w++) begin
      for (int h = 0; h <= int'(c[9]); h++) begin
        tick_k();
        chk({tag, " address"}, {24'd0, word_addr}, {24'd0, exp[63-8*w -: 8]});
        chk("R3 data valid", {31'd0, data_valid}, 32'd1);
        chk("R4 wait inactive with data", {31'd0, wait_out}, {31'd0, ~pol});
      end
    end
    @(negedge clk); ce = 1'b0;
    @(negedge clk);
    chk("R11 valid drops with ce", {31'd0, data_valid}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset configuration gives asynchronous pass-through
    ce = 1'b1; adv = 1'b1; start_addr = 8'h5A; act_lvl = 1'b1;
    tick_k();
    chk("R1 pass-through addr", {24'd0, word_addr}, 32'h5A);
    chk("R1 no valid", {31'd0, data_valid}, 32'd0);
    chk("R1 wait inactive", {31'd0, wait_out}, 32'd0);
    adv = 1'b0;
    tick_k(); tick_k(); tick_k();
    chk("R1 still no valid", {31'd0, data_valid}, 32'd0);
    start_addr = 8'hC3;
    @(negedge clk);
    chk("R1 addr follows input", {24'd0, word_addr}, 32'hC3);
    ce = 1'b0;

    // table of vectors
    for (int v = 0; v < NV; v++)
      run_burst(1'b1, V_CFG[v], V_ST[v], V_EXP[v], V_TAG[v]);

    // R2: illegal latency write is dropped (would have selected async mode)
    wr_cfg(16'h15C1);
    wr_cfg(16'h8DC1);
    run_burst(1'b0, 16'h15C1, 8'h06, V_EXP[0], "R2 illegal write ignored");

    // R9: inactive edge does not advance; R10: mid-burst write deferred
    act_lvl = 1'b1;
    @(negedge clk); ce = 1'b1; adv = 1'b1; start_addr = 8'h06;
    tick_k();
    adv = 1'b0;
    tick_k(); tick_k();
    chk("R9 first word", {24'd0, word_addr}, 32'h06);
    @(negedge clk); k_clk = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R9 falling edge ignored addr", {24'd0, word_addr}, 32'h06);
    chk("R9 falling edge ignored valid", {31'd0, data_valid}, 32'd1);
    @(negedge clk); k_clk = 1'b1;
    @(negedge clk);
    chk("R9 rising edge advances", {24'd0, word_addr}, 32'h07);
    wr_cfg(16'h25C9);
    tick_k();
    chk("R10 running burst keeps wrap", {24'd0, word_addr}, 32'h04);
    tick_k();
    chk("R10 running burst keeps wrap 2", {24'd0, word_addr}, 32'h05);
    @(negedge clk); ce = 1'b0;
    @(negedge clk);
    chk("R11 ce low mid-burst", {31'd0, data_valid}, 32'd0);
    run_burst(1'b0, 16'h25C9, 8'h3E, V_EXP[2], "R10 deferred cfg used");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule